// File: doc/BRIEF.md
# Board IO and Timer Register Block

This block is a small peripheral on a 32-bit register bus. A simple two-phase read/write port reaches it: a setup cycle with the select asserted, then an access cycle with the enable asserted. It keeps output bits for two indicator lights and a group of chip-select and control lines. It samples two push buttons through a two-flop synchroniser. It also runs three independent counters. Two of them advance at fixed rates of one and one hundred ticks per second, derived from a clock-frequency parameter. The third is an event counter paced by a programmable down-counting prescaler.

A write takes effect at the clock edge that ends the access cycle (select, enable and write all high). Read data is combinational while select is high and write is low. Registers sit on word offsets. An address whose two low bits are not zero matches no register. The counters can all be read and written by firmware, so software can preload them, snapshot them or realign the prescaler.

Top module: `board_io_timer`

## Requirements
- R1: The light register at offset 0x000 stores pwdata[1:0], drives `ledOut` from those bits and reads back with bits [31:2] as zero.
- R2: `buttonIn` passes through two flip-flops before it appears in bits [1:0] of offset 0x008, so a read sees the input as it was two clock edges earlier. Writes to 0x008 change nothing.
- R3: Offset 0x010 holds a 32-bit counter that advances by one every CLK_FREQ clock cycles. A bus write loads it.
- R4: Offset 0x014 holds a 32-bit counter that advances by one every CLK_FREQ/100 clock cycles. A bus write loads it.
- R5: A write to 0x010 or 0x014 changes only the count value. The internal divider phase continues, so the next advance comes at the same edge it would have come without the write.
- R6: Offset 0x024 is a prescale counter that drops by one each cycle. In the cycle after it reads zero it loads the reload value held at offset 0x020, so the period is reload+1 cycles. Both offsets can be read, and a write to 0x024 overwrites the count.
- R7: The 32-bit event counter at offset 0x018 advances by exactly one in each cycle in which the prescale counter is zero. A bus write loads it.
- R8: The control register at offset 0x04C stores pwdata[9:0] and drives `miscOut`, except bit 2, which is reserved: it reads as zero and drives zero.
- R9: When a bus write and a counter advance target the same register in the same cycle, the register takes the written value.
- R10: Reads of unmapped or misaligned addresses return zero, and writes to them change no register. After reset every register is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select (setup and access phases) |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high and pwrite is low |
| buttonIn | input | 2 | Raw push-button levels |
| ledOut | output | 2 | Indicator light drives |
| miscOut | output | 10 | Chip-select and control line drives |

## Verification
A bus write to a counter can land in the same cycle as that counter's own advance. This can happen on the fast tick counter and on the event counter. The bench forces the collision with a clock-frequency setting that makes the fast tick fire every cycle, and with a reload of zero that makes the event counter advance every cycle. Every write is therefore sure to coincide with an increment. The result is judged by reading back a fixed number of cycles later: the value must be the written value plus exactly the number of edges that have passed since the write, which cannot happen if the increment had won.

// File: rtl/bio_pkg.sv
`timescale 1ns/1ps
package bio_pkg;

  // Word offsets (byte offset / 4) of each register
  localparam int OFS_LED    = 0;
  localparam int OFS_BTN    = 2;
  localparam int OFS_HZ1    = 4;
  localparam int OFS_HZ100  = 5;
  localparam int OFS_CYCLE  = 6;
  localparam int OFS_RELOAD = 8;
  localparam int OFS_PSCNT  = 9;
  localparam int OFS_MISC   = 19;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_LED,
    SEL_BTN,
    SEL_HZ1,
    SEL_HZ100,
    SEL_CYCLE,
    SEL_RELOAD,
    SEL_PSCNT,
    SEL_MISC
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    wrLed;
    logic    wrMisc;
    logic    wrHz1;
    logic    wrHz100;
    logic    wrCycle;
    logic    wrReload;
    logic    wrPsCnt;
    logic    tickHz1;
    logic    tickHz100;
    regSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/bio_tick_div.sv
`timescale 1ns/1ps
module bio_tick_div #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phaseCnt;

  assign tick = (phaseCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     phaseCnt <= '0;
    else if (tick) phaseCnt <= '0;
    else           phaseCnt <= phaseCnt + 1'b1;
  end
endmodule

// File: rtl/bio_ctrl.sv
`timescale 1ns/1ps
module bio_ctrl
  import bio_pkg::*;
#(
  parameter int unsigned CLK_FREQ = 50_000_000,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output strobes_t          strobes
);
  localparam int WI_W = ADDR_W - 2;
  localparam int unsigned DIV_HZ1   = (CLK_FREQ > 0) ? CLK_FREQ : 1;
  localparam int unsigned DIV_HZ100 = (CLK_FREQ >= 100) ? CLK_FREQ / 100 : 1;

  logic [WI_W-1:0] wordIdx;
  logic aligned, wrAccess, rdAccess;
  logic tickHz1, tickHz100;

  assign wordIdx  = paddr[ADDR_W-1:2];
  assign aligned  = (paddr[1:0] == 2'b00);
  assign wrAccess = psel & penable & pwrite & aligned;
  assign rdAccess = psel & ~pwrite & aligned;

  bio_tick_div #(.DIV(DIV_HZ1))   i_divHz1   (.clk(clk), .rstN(rstN), .tick(tickHz1));
  bio_tick_div #(.DIV(DIV_HZ100)) i_divHz100 (.clk(clk), .rstN(rstN), .tick(tickHz100));

  always_comb begin
    strobes           = '0;
    strobes.rdSel     = SEL_NONE;
    strobes.tickHz1   = tickHz1;
    strobes.tickHz100 = tickHz100;
    if (wrAccess) begin
      strobes.wrLed    = (wordIdx == WI_W'(OFS_LED));
      strobes.wrMisc   = (wordIdx == WI_W'(OFS_MISC));
      strobes.wrHz1    = (wordIdx == WI_W'(OFS_HZ1));
      strobes.wrHz100  = (wordIdx == WI_W'(OFS_HZ100));
      strobes.wrCycle  = (wordIdx == WI_W'(OFS_CYCLE));
      strobes.wrReload = (wordIdx == WI_W'(OFS_RELOAD));
      strobes.wrPsCnt  = (wordIdx == WI_W'(OFS_PSCNT));
    end
    if (rdAccess) begin
      if      (wordIdx == WI_W'(OFS_LED))    strobes.rdSel = SEL_LED;
      else if (wordIdx == WI_W'(OFS_BTN))    strobes.rdSel = SEL_BTN;
      else if (wordIdx == WI_W'(OFS_HZ1))    strobes.rdSel = SEL_HZ1;
      else if (wordIdx == WI_W'(OFS_HZ100))  strobes.rdSel = SEL_HZ100;
      else if (wordIdx == WI_W'(OFS_CYCLE))  strobes.rdSel = SEL_CYCLE;
      else if (wordIdx == WI_W'(OFS_RELOAD)) strobes.rdSel = SEL_RELOAD;
      else if (wordIdx == WI_W'(OFS_PSCNT))  strobes.rdSel = SEL_PSCNT;
      else if (wordIdx == WI_W'(OFS_MISC))   strobes.rdSel = SEL_MISC;
    end
  end
endmodule

// File: rtl/bio_datapath.sv
`timescale 1ns/1ps
module bio_datapath
  import bio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_W = 2,
  parameter int BTN_W = 2,
  parameter int MISC_W = 10,
  parameter int MISC_RSVD_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BTN_W-1:0]  buttonIn,
  output logic [DATA_W-1:0] rdData,
  output logic [LED_W-1:0]  ledOut,
  output logic [MISC_W-1:0] miscOut
);
  localparam logic [MISC_W-1:0] MISC_MASK = ~(MISC_W'(1) << MISC_RSVD_BIT);

  logic [BTN_W-1:0]  btnMeta, btnSync;
  logic [LED_W-1:0]  ledReg;
  logic [MISC_W-1:0] miscReg;
  logic [DATA_W-1:0] hz1Count, hz100Count, cycleCount, reloadReg, psCount;
  logic psZero;

  assign psZero  = (psCount == '0);
  assign ledOut  = ledReg;
  assign miscOut = miscReg;

  // Two-flop button synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      btnMeta <= '0;
      btnSync <= '0;
    end else begin
      btnMeta <= buttonIn;
      btnSync <= btnMeta;
    end
  end

  // Plain control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledReg    <= '0;
      miscReg   <= '0;
      reloadReg <= '0;
    end else begin
      if (strobes.wrLed)    ledReg    <= wrData[LED_W-1:0];
      if (strobes.wrMisc)   miscReg   <= wrData[MISC_W-1:0] & MISC_MASK;
      if (strobes.wrReload) reloadReg <= wrData;
    end
  end

  // Rate counters: bus write has priority over tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hz1Count   <= '0;
      hz100Count <= '0;
    end else begin
      if (strobes.wrHz1)        hz1Count <= wrData;
      else if (strobes.tickHz1) hz1Count <= hz1Count + 1'b1;
      if (strobes.wrHz100)        hz100Count <= wrData;
      else if (strobes.tickHz100) hz100Count <= hz100Count + 1'b1;
    end
  end

  // Prescaler and event counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCount    <= '0;
      cycleCount <= '0;
    end else begin
      if (strobes.wrPsCnt) psCount <= wrData;
      else if (psZero)     psCount <= reloadReg;
      else                 psCount <= psCount - 1'b1;
      if (strobes.wrCycle) cycleCount <= wrData;
      else if (psZero)     cycleCount <= cycleCount + 1'b1;
    end
  end

  // Read mux
  always_comb begin
    unique case (strobes.rdSel)
      SEL_LED:    rdData = DATA_W'(ledReg);
      SEL_BTN:    rdData = DATA_W'(btnSync);
      SEL_HZ1:    rdData = hz1Count;
      SEL_HZ100:  rdData = hz100Count;
      SEL_CYCLE:  rdData = cycleCount;
      SEL_RELOAD: rdData = reloadReg;
      SEL_PSCNT:  rdData = psCount;
      SEL_MISC:   rdData = DATA_W'(miscReg);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/board_io_timer.sv
`timescale 1ns/1ps
module board_io_timer
  import bio_pkg::*;
#(
  parameter int unsigned CLK_FREQ = 50_000_000,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LED_W = 2,
  parameter int BTN_W = 2,
  parameter int MISC_W = 10,
  parameter int MISC_RSVD_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [BTN_W-1:0]  buttonIn,
  output logic [LED_W-1:0]  ledOut,
  output logic [MISC_W-1:0] miscOut
);
  strobes_t strobes;

  bio_ctrl #(.CLK_FREQ(CLK_FREQ), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .strobes(strobes)
  );

  bio_datapath #(
    .DATA_W(DATA_W), .LED_W(LED_W), .BTN_W(BTN_W),
    .MISC_W(MISC_W), .MISC_RSVD_BIT(MISC_RSVD_BIT)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(pwdata),
    .buttonIn(buttonIn), .rdData(prdata), .ledOut(ledOut), .miscOut(miscOut)
  );
endmodule

// File: rtl/bio_checker.sv
`timescale 1ns/1ps
module bio_checker (
  input logic        clk,
  input logic        rstN,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic [31:0] prdata,
  input logic [1:0]  buttonIn,
  input logic [1:0]  ledOut,
  input logic [9:0]  miscOut
);
  logic [1:0] upCnt;
  logic wrAny, rdAny, settled, mapped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 1'b1;
  end

  assign settled = (upCnt == 2'd3);
  assign wrAny   = psel & penable & pwrite;
  assign rdAny   = psel & ~pwrite;
  assign mapped  = (paddr == 12'h000) || (paddr == 12'h008) || (paddr == 12'h010) ||
                   (paddr == 12'h014) || (paddr == 12'h018) || (paddr == 12'h020) ||
                   (paddr == 12'h024) || (paddr == 12'h04C);

  p_led_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAny && paddr == 12'h000) |=> $stable(ledOut));

  p_misc_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAny && paddr == 12'h04C) |=> $stable(miscOut));

  p_btn_delay_r2: assert property (@(posedge clk) disable iff (!rstN)
    (settled && rdAny && paddr == 12'h008) |-> prdata[1:0] == $past(buttonIn, 2));

  p_ps_down_r6: assert property (@(posedge clk) disable iff (!rstN)
    (settled && rdAny && paddr == 12'h024 && $past(rdAny && paddr == 12'h024) &&
     $past(prdata) != 32'd0) |-> prdata == $past(prdata) - 32'd1);

  p_cycle_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (settled && rdAny && paddr == 12'h018 && $past(rdAny && paddr == 12'h018)) |->
    (prdata == $past(prdata) || prdata == $past(prdata) + 32'd1));

  p_hz1_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (settled && rdAny && paddr == 12'h010 && $past(rdAny && paddr == 12'h010)) |->
    (prdata == $past(prdata) || prdata == $past(prdata) + 32'd1));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdAny && !mapped) |-> prdata == 32'd0);
endmodule

bind board_io_timer bio_checker i_bioChecker (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .buttonIn(buttonIn), .ledOut(ledOut),
  .miscOut(miscOut)
);

// File: tb/test_board_io_timer.sv
`timescale 1ns/1ps
module test_board_io_timer;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned BENCH_FREQ = 100; // fast tick every cycle, slow tick every 100

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [1:0] buttonIn = '0;
  logic [1:0] ledOut;
  logic [9:0] miscOut;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;

  board_io_timer #(.CLK_FREQ(BENCH_FREQ)) i_board_io_timer (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .buttonIn(buttonIn),
    .ledOut(ledOut), .miscOut(miscOut)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(posedge clk);
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic holdStart(input logic [11:0] a);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1;
  endtask

  task automatic holdStop();
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic waitChange(input logic [31:0] prev, output int at, output logic [31:0] nv);
    at = -1; nv = prev;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (prdata !== prev) begin at = cyc; nv = prdata; break; end
    end
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R10 reset ledOut", 32'(ledOut), 32'h0);
    check("R10 reset miscOut", 32'(miscOut), 32'h0);
    busRead(12'h010, v); check("R10 reset slow counter", v, 32'h0);
    busRead(12'h020, v); check("R10 reset reload", v, 32'h0);
    busRead(12'h04C, v); check("R10 reset misc", v, 32'h0);
  endtask

  task automatic testLed();
    logic [31:0] v;
    busWrite(12'h000, 32'hFFFF_FFFF);
    busRead(12'h000, v); check("R1 led readback masked", v, 32'h3);
    check("R1 ledOut all on", 32'(ledOut), 32'h3);
    busWrite(12'h000, 32'h0000_0002);
    check("R1 ledOut pattern", 32'(ledOut), 32'h2);
  endtask

  task automatic testMisc();
    logic [31:0] v;
    busWrite(12'h04C, 32'hFFFF_FFFF);
    busRead(12'h04C, v); check("R8 misc readback, bit2 zero", v, 32'h3FB);
    check("R8 miscOut", 32'(miscOut), 32'h3FB);
    busWrite(12'h04C, 32'h0000_0004);
    busRead(12'h04C, v); check("R8 reserved bit alone", v, 32'h0);
    busWrite(12'h04C, 32'h0000_0201);
    check("R8 miscOut pattern", 32'(miscOut), 32'h201);
  endtask

  task automatic testButtons();
    logic [31:0] v;
    buttonIn = 2'b01;
    repeat (3) @(posedge clk);
    busRead(12'h008, v); check("R2 button sampled", v, 32'h1);
    busWrite(12'h008, 32'h3);
    busRead(12'h008, v); check("R2 button write ignored", v, 32'h1);
    buttonIn = 2'b10;
    @(posedge clk); #1;
    busRead(12'h008, v); check("R2 button change", v, 32'h2);
  endtask

  task automatic testSlowTick();
    logic [31:0] v0, v1, v2;
    int tA, tB, tC;
    holdStart(12'h010); v0 = prdata;
    waitChange(v0, tA, v1);
    waitChange(v1, tB, v2);
    check("R3 slow tick period", 32'(tB - tA), 32'd100);
    check("R3 slow tick step", v2, v1 + 32'd1);
    holdStop();
    repeat (30) @(posedge clk);
    busWrite(12'h010, 32'd50);
    holdStart(12'h010); v0 = prdata;
    check("R3 slow counter write", v0, 32'd50);
    waitChange(v0, tC, v1);
    check("R5 divider phase kept", 32'(tC - tB), 32'd100);
    check("R3 slow counter counts on", v1, 32'd51);
    holdStop();
  endtask

  task automatic testFastTick();
    logic [31:0] v0, v1;
    holdStart(12'h014); v0 = prdata;
    repeat (37) @(negedge clk); #1 v1 = prdata;
    check("R4 fast tick rate", v1 - v0, 32'd37);
    holdStop();
    // R9: every write collides with a tick in this configuration
    busWrite(12'h014, 32'd777);
    busRead(12'h014, v0);
    check("R9 write beats fast tick", v0, 32'd779);
    check("R5 fast counter continues", 32'(v0 > 32'd777), 32'd1);
  endtask

  task automatic testPrescaler();
    logic [31:0] v0, v1;
    busWrite(12'h020, 32'd1000);
    busWrite(12'h024, 32'd100);
    busRead(12'h024, v0); check("R6 prescale down count", v0, 32'd98);
    busRead(12'h020, v0); check("R6 reload readback", v0, 32'd1000);
    busWrite(12'h020, 32'd4);
    busWrite(12'h024, 32'd0);
    busRead(12'h024, v0); check("R6 reload after zero", v0, 32'd3);
    holdStart(12'h018); v0 = prdata;
    repeat (50) @(negedge clk); #1 v1 = prdata;
    check("R7 event count per period", v1 - v0, 32'd10);
    holdStop();
    busWrite(12'h020, 32'd0);
    busWrite(12'h024, 32'd0);
    busWrite(12'h018, 32'd500);
    busRead(12'h018, v0); check("R9 write beats event increment", v0, 32'd502);
    busRead(12'h024, v0); check("R6 zero reload stays zero", v0, 32'd0);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    busWrite(12'h01C, 32'hFFFF_FFFF);
    busRead(12'h01C, v); check("R10 unmapped read", v, 32'h0);
    busWrite(12'h001, 32'h0);
    check("R10 misaligned write no effect", 32'(ledOut), 32'h2);
    busRead(12'h04E, v); check("R10 misaligned read", v, 32'h0);
    busRead(12'h048, v); check("R10 neighbour read", v, 32'h0);
    check("R10 misc untouched", 32'(miscOut), 32'h201);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    testReset();
    testLed();
    testMisc();
    testButtons();
    testSlowTick();
    testFastTick();
    testPrescaler();
    testUnmapped();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule